// File: doc/BRIEF.md
# Variable bit-field extractor

This unit pulls a contiguous field out of a 32-bit word, where both the field's starting bit and its width are chosen at run time. The selected field is right-aligned and returned two ways at once: padded with zeros as an unsigned value, and padded with copies of its top bit as a two's-complement value. Typical users are decode or unpack stages that receive packed records whose layout is known only from a descriptor.

A request is taken when `valid_i` is high. The results and `valid_o` are registered, so they appear one clock later. Back-to-back requests are accepted on every cycle. Widths larger than the data word are clamped. A field that would run past bit 31 is cut off at bit 31, and the shortened field is what gets sign-extended. A width of zero selects an empty field.

Top module: `bit_field_extract`

## Requirements
- R1: `valid_o` is high in exactly the cycles that follow a clock edge at which `valid_i` was high. Reset drives `valid_o`, `zext_o` and `sext_o` to zero.
- R2: `zext_o` bits [k-1:0] equal `value_i` bits [pos_i+k-1:pos_i], where k is the effective width. All higher bits of `zext_o` are zero.
- R3: `sext_o` equals `zext_o` in its low k bits. All higher bits copy bit k-1 of the field (bit pos_i+k-1 of `value_i`).
- R4: When `width_i` is 0, the field is empty and both `zext_o` and `sext_o` are zero for that request.
- R5: When pos_i + width is greater than 32, the effective width is 32 - pos_i. The field's sign bit is then bit 31 of `value_i`.
- R6: A `width_i` value from 33 to 63 is treated as 32.
- R7: With `pos_i` = 0 and a width of 32, both outputs equal `value_i`.
- R8: In any cycle that follows an edge at which `valid_i` was low, `zext_o` and `sext_o` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| value_i | input | 32 | Source word |
| pos_i | input | 5 | Bit index of the field's least significant bit |
| width_i | input | 6 | Requested field width (0 to 63) |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| zext_o | output | 32 | Field, zero-extended |
| sext_o | output | 32 | Field, sign-extended |

## Verification
Several properties are checked on every cycle:
- the one-cycle relation between the strobe and `valid_o`;
- that results hold while no request is made;
- that a zero width gives zero outputs;
- that the generated mask contains exactly as many ones as the effective width;
- that the unsigned result has no bits above that width;
- that the signed result agrees with the unsigned one in its low bits and fills the upper bits with a single value.

These checks do not show that the right bits were selected, or that the correct sign was copied. Only the bench's vectors of known answers can show that. The vectors cover the truncation at bit 31, width clamping, single-bit fields at both ends of the word and full-word pass-through.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned POS_W  = $clog2(DATA_W);
  localparam int unsigned WID_W  = POS_W + 1;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [WID_W-1:0]  wid_t;
endpackage

// File: rtl/bfx_mask_gen.sv
module bfx_mask_gen
  import bfx_pkg::*;
(
  input  pos_t  pos_i,
  input  wid_t  width_i,
  output wid_t  eff_w_o,
  output word_t mask_o
);
  localparam wid_t DW = wid_t'(DATA_W);

  wid_t  clamp_w;
  wid_t  room_w;
  word_t low_mask;

  always_comb begin
    clamp_w = (width_i > DW) ? DW : width_i;
    room_w  = DW - wid_t'(pos_i);
    eff_w_o = (clamp_w > room_w) ? room_w : clamp_w;
    if (eff_w_o == '0) low_mask = '0;
    else               low_mask = {DATA_W{1'b1}} >> (DW - eff_w_o);
    mask_o = low_mask << pos_i;
  end
endmodule

// File: rtl/bfx_align.sv
module bfx_align
  import bfx_pkg::*;
(
  input  word_t value_i,
  input  word_t mask_i,
  input  pos_t  pos_i,
  input  wid_t  eff_w_i,
  output word_t zext_o,
  output word_t sext_o
);
  localparam wid_t DW = wid_t'(DATA_W);

  word_t              masked;
  wid_t               lsh;
  wid_t               rsh;
  logic signed [DATA_W-1:0] top_aligned;

  always_comb begin
    masked      = value_i & mask_i;
    zext_o      = masked >> pos_i;
    // move field MSB to the word MSB, then arithmetic shift back
    lsh         = DW - (wid_t'(pos_i) + eff_w_i);
    rsh         = DW - eff_w_i;
    top_aligned = $signed(masked << lsh);
    if (eff_w_i == '0) sext_o = '0;
    else               sext_o = word_t'(top_aligned >>> rsh);
  end
endmodule

// File: rtl/bit_field_extract.sv
module bit_field_extract
  import bfx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] value_i,
  input  logic [4:0]  pos_i,
  input  logic [5:0]  width_i,
  output logic        valid_o,
  output logic [31:0] zext_o,
  output logic [31:0] sext_o
);
  localparam wid_t DW = wid_t'(DATA_W);

  wid_t  eff_w;
  word_t mask;
  word_t zext_c;
  word_t sext_c;

  bfx_mask_gen u_mask (
    .pos_i   (pos_i),
    .width_i (width_i),
    .eff_w_o (eff_w),
    .mask_o  (mask)
  );

  bfx_align u_align (
    .value_i (value_i),
    .mask_i  (mask),
    .pos_i   (pos_i),
    .eff_w_i (eff_w),
    .zext_o  (zext_c),
    .sext_o  (sext_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      zext_o  <= '0;
      sext_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        zext_o <= zext_c;
        sext_o <= sext_c;
      end
    end
  end

  // R1
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(zext_o) && $stable(sext_o)));
  // R4
  zero_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && width_i == '0) |=> (zext_o == '0 && sext_o == '0));
  // R2
  mask_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ($countones(mask) == int'(eff_w)));
  // R2
  zext_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eff_w < DW) |-> ((zext_c >> eff_w) == '0));
  // R3
  sext_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (((zext_c ^ sext_c) & (mask >> pos_i)) == '0));
  // R3
  sext_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eff_w != '0) |->
      ((sext_c >> (eff_w - 1'b1)) == '0 ||
       (sext_c >> (eff_w - 1'b1)) == ({DATA_W{1'b1}} >> (eff_w - 1'b1))));
endmodule

// File: tb/bit_field_extract_tb.sv
`timescale 1ns/1ps
module bit_field_extract_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] value_i = '0;
  logic [4:0]  pos_i = '0;
  logic [5:0]  width_i = '0;
  logic        valid_o;
  logic [31:0] zext_o, sext_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bit_field_extract u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .value_i(value_i),
    .pos_i(pos_i), .width_i(width_i), .valid_o(valid_o),
    .zext_o(zext_o), .sext_o(sext_o)
  );

  localparam int NV = 12;
  localparam logic [31:0] T_VAL [NV] = '{
    32'h0000_00AD, 32'h0020_1000, 32'hDEAD_BEEF, 32'h1234_5678,
    32'h1234_5678, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'hABCD_1234, 32'h7FFF_FFFF, 32'h5555_AAAA, 32'h0000_0400};
  localparam logic [4:0] T_POS [NV] = '{
    5'd3, 5'd12, 5'd0, 5'd4, 5'd0, 5'd28, 5'd31, 5'd0, 5'd16, 5'd0, 5'd8, 5'd10};
  localparam logic [5:0] T_WID [NV] = '{
    6'd5, 6'd10, 6'd32, 6'd8, 6'd0, 6'd8, 6'd1, 6'd1, 6'd40, 6'd63, 6'd16, 6'd1};
  localparam logic [31:0] T_Z [NV] = '{
    32'h15, 32'h201, 32'hDEAD_BEEF, 32'h67, 32'h0, 32'h8, 32'h1, 32'h1,
    32'hABCD, 32'h7FFF_FFFF, 32'h55AA, 32'h1};
  localparam logic [31:0] T_S [NV] = '{
    32'hFFFF_FFF5, 32'hFFFF_FE01, 32'hDEAD_BEEF, 32'h67, 32'h0, 32'hFFFF_FFF8,
    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_ABCD, 32'h7FFF_FFFF, 32'h55AA,
    32'hFFFF_FFFF};
  // requirement tag per vector
  localparam string T_REQ [NV] = '{
    "R2/R3", "R3", "R7", "R2", "R4", "R5", "R5", "R3", "R6", "R6/R7",
    "R2", "R3"};

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_result(input int i);
    check(T_REQ[i], "valid_o", {31'b0, valid_o}, 32'd1);  // R1
    check(T_REQ[i], "zext_o", zext_o, T_Z[i]);
    check(T_REQ[i], "sext_o", sext_o, T_S[i]);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    // R1 reset state
    valid_i = 1'b1;
    value_i = 32'hFFFF_FFFF;
    width_i = 6'd8;
    repeat (3) @(negedge clk);
    check("R1", "reset valid_o", {31'b0, valid_o}, 32'd0);
    check("R1", "reset zext_o", zext_o, 32'd0);
    check("R1", "reset sext_o", sext_o, 32'd0);
    valid_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle valid_o", {31'b0, valid_o}, 32'd0);

    // back-to-back table walk
    for (int i = 0; i <= NV; i++) begin
      if (i > 0) check_result(i - 1);
      if (i < NV) begin
        valid_i = 1'b1;
        value_i = T_VAL[i];
        pos_i   = T_POS[i];
        width_i = T_WID[i];
        @(negedge clk);
      end else begin
        valid_i = 1'b0;
      end
    end

    // R8: inputs change with valid low, outputs hold the last result
    value_i = 32'h0F0F_0F0F;
    pos_i   = 5'd0;
    width_i = 6'd32;
    repeat (3) @(negedge clk);
    check("R8", "hold zext_o", zext_o, T_Z[NV-1]);
    check("R8", "hold sext_o", sext_o, T_S[NV-1]);
    check("R1", "valid_o low after idle", {31'b0, valid_o}, 32'd0);

    // R1 single pulse, R5 truncated positive field
    valid_i = 1'b1;
    value_i = 32'h7000_0000;
    pos_i   = 5'd29;
    width_i = 6'd10;
    @(negedge clk);
    valid_i = 1'b0;
    check("R5", "trunc zext_o", zext_o, 32'h3);
    check("R5", "trunc sext_o", sext_o, 32'h3);
    check("R1", "pulse valid_o", {31'b0, valid_o}, 32'd1);
    @(negedge clk);
    check("R1", "pulse end valid_o", {31'b0, valid_o}, 32'd0);

    // R4 zero width at a nonzero position with all ones
    valid_i = 1'b1;
    value_i = 32'hFFFF_FFFF;
    pos_i   = 5'd17;
    width_i = 6'd0;
    @(negedge clk);
    valid_i = 1'b0;
    check("R4", "empty zext_o", zext_o, 32'h0);
    check("R4", "empty sext_o", sext_o, 32'h0);

    // R1 mid-run reset clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "reclear zext_o", zext_o, 32'h0);
    check("R1", "reclear valid_o", {31'b0, valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule